// File: doc/BRIEF.md
# Lookup-Mapped Arbitrary Sequence Counter

This block produces a fixed, non-monotonic 4-bit code sequence. The sequence runs 0, 4, 2, 8, 10, 0, 11, 9 and then repeats. Underneath it is an ordinary 3-bit binary core built from toggle stages. On each enabled clock edge the core advances by one and wraps from 7 back to 0. A lookup function maps each core state onto its code.

The code is registered from the decode of the core's next state. Both the code and the state therefore change on the same clock edge, and the code output cannot glitch. The value 0 occurs twice in each period, so a consumer cannot tell where it is in the sequence from the code alone. For that reason the core state is also brought out.

The design has one clock. Reset is synchronous and active high, and an enable input gates advancement.

Top module: `seq_lookup_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `state_out` becomes 0 and `seq_out` becomes 0 after that edge, whatever the value of `en`.
- R2: With `rst` low and `en` high, `state_out` increases by exactly 1 at every rising edge. Bit i of the state inverts exactly when all bits below it are 1.
- R3: An enabled edge taken from state 7 moves `state_out` to 0.
- R4: With `rst` low and `en` low, `state_out` and `seq_out` keep their values across the edge.
- R5: `seq_out` equals the code for the current state. States 0,1,2,3,4,5,6,7 map to codes 0,4,2,8,10,0,11,9, so code 0 appears at both state 0 and state 5.
- R6: `seq_out` is a register output. It takes the code of the new state on the same edge that updates `state_out`, with no cycle of lag.
- R7: Reset is synchronous. Raising `rst` between edges leaves both outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; the core advances only when high |
| seq_out | output | 4 | Registered sequence code |
| state_out | output | 3 | Current core state, for observation |

## Verification
A fault in the toggle chain shows up on `state_out` at the first edge where the bad carry is used. For the top bit, that can take up to a full 8-cycle period. A fault in the decode or the code register shows up one sample after the edge, as a mismatch between `seq_out` and the code expected for `state_out`. The repeated code 0 could hide a state fault in `seq_out` alone, so the bench compares the state and the code separately on every cycle over several periods.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;
  localparam int STATE_W = 3;
  localparam int CODE_W  = 4;
  localparam int PERIOD  = 1 << STATE_W;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [CODE_W-1:0]  code_t;

  // Fixed code table indexed by core state
  function automatic code_t seq_map(input state_t s);
    code_t c;
    case (s)
      3'd0: c = 4'd0;
      3'd1: c = 4'd4;
      3'd2: c = 4'd2;
      3'd3: c = 4'd8;
      3'd4: c = 4'd10;
      3'd5: c = 4'd0;
      3'd6: c = 4'd11;
      default: c = 4'd9;
    endcase
    return c;
  endfunction

  // Next state of a toggle chain: bit i flips when carry into it is set
  function automatic state_t toggle_next(input state_t s, input logic adv);
    state_t n;
    logic carry;
    carry = adv;
    for (int i = 0; i < STATE_W; i++) begin
      n[i]  = s[i] ^ carry;
      carry = carry & s[i];
    end
    return n;
  endfunction
endpackage

// File: rtl/seqcnt_toggle_core.sv
module seqcnt_toggle_core #(
  parameter int W = seqcnt_pkg::STATE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] state,
  output logic [W-1:0] state_nxt,
  output logic         wrap_evt
);
  logic [W:0] carry;

  assign carry[0] = en;

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      assign carry[i+1]   = carry[i] & state[i];
      assign state_nxt[i] = rst ? 1'b0 : (state[i] ^ carry[i]);
      always_ff @(posedge clk) begin
        state[i] <= state_nxt[i];
      end
    end
  endgenerate

  assign wrap_evt = carry[W] & ~rst;
endmodule

// File: rtl/seqcnt_decode.sv
module seqcnt_decode
  import seqcnt_pkg::*;
(
  input  state_t state_in,
  output code_t  code
);
  always_comb begin
    code = seq_map(state_in);
  end
endmodule

// File: rtl/seqcnt_out_reg.sv
module seqcnt_out_reg #(
  parameter int W = seqcnt_pkg::CODE_W
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/seq_lookup_counter.sv
module seq_lookup_counter
  import seqcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [CODE_W-1:0] seq_out,
  output logic [STATE_W-1:0] state_out
);
  state_t state_q;
  state_t state_nxt;
  code_t  code_nxt;
  logic   wrap_evt;

  seqcnt_toggle_core #(.W(STATE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .state     (state_q),
    .state_nxt (state_nxt),
    .wrap_evt  (wrap_evt)
  );

  // Decode the next state so the code lands on the same edge as the state
  seqcnt_decode u_dec (
    .state_in (state_nxt),
    .code     (code_nxt)
  );

  seqcnt_out_reg #(.W(CODE_W)) u_oreg (
    .clk (clk),
    .d   (code_nxt),
    .q   (seq_out)
  );

  assign state_out = state_q;
endmodule

// File: rtl/seqcnt_chk.sv
module seqcnt_chk
  import seqcnt_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   en,
  input code_t  seq_out,
  input state_t state_out,
  input logic   wrap_evt
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (state_out == '0 && seq_out == '0));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> state_out == state_t'($past(state_out) + 1'b1));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> state_out == '0);

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state_out));

  // R4
  hold_code_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(seq_out));

  // R6
  code_tracks_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> seq_out == seq_map(state_out));
endmodule

bind seq_lookup_counter seqcnt_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .seq_out   (seq_out),
  .state_out (state_out),
  .wrap_evt  (wrap_evt)
);

// File: tb/tb_seq_lookup_counter.sv
module tb_seq_lookup_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] seq_out;
  logic [2:0] state_out;

  int checks = 0;
  int fails  = 0;
  int exp_st = 0;
  bit done   = 0;

  localparam logic [3:0] CODES [8] = '{4'd0, 4'd4, 4'd2, 4'd8, 4'd10, 4'd0, 4'd11, 4'd9};

  always #5 clk = ~clk;

  seq_lookup_counter dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .seq_out   (seq_out),
    .state_out (state_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, apply one edge, sample 1 ns after it
  task automatic cycle(input logic r, input logic e, input string stag);
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) exp_st = 0;
    else if (e) exp_st = (exp_st + 1) % 8;
    #1;
    chk(stag, int'(state_out), exp_st);
    chk(r ? "R1" : "R6", int'(seq_out), int'(CODES[exp_st]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, also with en high
    cycle(1'b1, 1'b0, "R1");
    cycle(1'b1, 1'b1, "R1");
    cycle(1'b1, 1'b1, "R1");

    // R2, R3, R5: three full periods with the code checked every cycle
    for (int i = 0; i < 24; i++) begin
      cycle(1'b0, 1'b1, (exp_st == 7) ? "R3" : "R2");
      chk("R5", int'(seq_out), int'(CODES[state_out]));
    end

    // R5: code 0 appears at states 0 and 5
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, 1'b1, "R2");
      if (exp_st == 0 || exp_st == 5) chk("R5", int'(seq_out), 0);
    end

    // R4: mixed enable pattern, holds included
    for (int i = 0; i < 40; i++) begin
      logic e;
      e = ((i * 5 + 3) % 7) < 3;
      cycle(1'b0, e, e ? "R2" : "R4");
    end

    // R7: raise reset mid-cycle at a nonzero state
    while (exp_st == 0) cycle(1'b0, 1'b1, "R2");
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    #2;
    chk("R7", int'(state_out), exp_st);
    chk("R7", int'(seq_out), int'(CODES[exp_st]));
    @(posedge clk);
    exp_st = 0;
    #1;
    chk("R1", int'(state_out), 0);
    chk("R1", int'(seq_out), 0);

    // Recovery after reset: another full period
    for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1, (exp_st == 7) ? "R3" : "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule